// File: doc/BRIEF.md
# Per-Bit Sampler Offset Calibrator

This block trims the input sampler of each bit lane in a byte of a receive path while the bus sits idle at mid-rail. It steps one shared 4-bit offset code upward through the whole trim range and writes it into every lane field of a packed trim word. For each step it raises a sample-train strobe and holds it for a programmable settle time. It reads one feedback bit per lane on the last cycle of that strobe and then drops the strobe.

For every lane the block keeps two records. One is the earliest code at which the lane read 0. The other is the latest code at which the lane read 1. When the sweep ends it turns each pair into a centred trim code. A lane that never read 0 is pinned to the top of the range, and a lane that never read 1 is pinned to the bottom. All lane codes come out together as one packed result word, with a single-cycle completion pulse.

Eight lanes are always trained. A mode input, captured at start, adds a ninth lane that carries the data strobe's sampler.

Top module: `sampler_offset_cal`

## Requirements
- R1: After reset, `done`, `train_strobe`, `ofs_word` and `result` are all zero.
- R2: After `start`, the shared code takes the values 1 to 15 in rising order, one value per strobe pulse. While a pulse is high, every active lane field `ofs_word[4i+3:4i]` equals the current code.
- R3: Each strobe pulse is high for exactly `SETTLE_CYC` cycles. Consecutive pulses are separated by exactly one low cycle, and a run has exactly 15 pulses.
- R4: A lane's "last one" record is the highest code at which its feedback bit read 1 in the final cycle of that code's strobe pulse. The record is 0 if the lane never read 1.
- R5: A lane's "first zero" record is the lowest code at which the lane read 0. Later zeros do not change it. The record is 0 if the lane never read 0.
- R6: When both records are non-zero, the lane result is floor((first zero + last one) / 2), limited to 0..15. The sum is formed one bit wider than a code.
- R7: A lane that never read 0 gets result 15.
- R8: A lane that never read 1 gets result 0. This override wins over R7.
- R9: With `strobe_lane_en` high at start, lane 8 (bits [35:32]) is swept and trained like the others. With it low, lane 8's offset field and result field stay 0.
- R10: `done` is high for exactly one cycle per run. `result[4i+3:4i]` is lane i's code from that cycle on. It holds unchanged until the next run completes.
- R11: A `start` pulse, or a change of `strobe_lane_en`, while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a calibration run when idle |
| strobe_lane_en | input | 1 | Adds the ninth (strobe) lane to the run; captured at start |
| fb | input | 9 | Per-lane sampler feedback, lane i on bit i |
| ofs_word | output | 36 | Packed trim code being applied, lane i at [4i+3:4i] |
| train_strobe | output | 1 | Sample-train strobe, high while a code settles |
| result | output | 36 | Packed calibrated trim codes, lane i at [4i+3:4i] |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
A wrong step counter or a stuck code shows at `ofs_word` on the very next strobe rise. It also shows as a pulse count other than 15 before `done`. A corrupted tracker cannot be seen until the single `done` cycle, so the feedback patterns are chosen to make each lane's result depend on exactly one record or override: a late zero that must be ignored, a one after a zero, feedback that is all high, and feedback that is all low. A fault in a tracker or in the centring arithmetic then changes a specific result nibble. A mode latch that follows the live input shows only when the input moves mid-run, so one run does exactly that.

// File: rtl/samp_cal_pkg.sv
package samp_cal_pkg;
  localparam int OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_GAP, ST_CALC} cal_state_e;

  // Centre of a lane's transition window with saturation overrides.
  function automatic logic [OFS_W-1:0] centre_code(input logic [OFS_W-1:0] first_zero,
                                                   input logic [OFS_W-1:0] last_one);
    logic [OFS_W:0]   sum;
    logic [OFS_W:0]   half;
    logic [OFS_W-1:0] code;
    sum  = {1'b0, first_zero} + {1'b0, last_one};
    half = sum >> 1;
    code = (half > {1'b0, OFS_MAX}) ? OFS_MAX : half[OFS_W-1:0];
    if (first_zero == '0) code = OFS_MAX;
    if (last_one == '0)   code = '0;
    return code;
  endfunction
endpackage

// File: rtl/samp_cal_seq.sv
module samp_cal_seq
  import samp_cal_pkg::*;
#(
  parameter int SETTLE_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_in,
  output logic [OFS_W-1:0] code,
  output logic             strobe,
  output logic             sample_now,
  output logic             clear_trk,
  output logic             calc_now,
  output logic             sweep_on,
  output logic             mode_q
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  cal_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      code   <= '0;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SETTLE;
          code   <= OFS_W'(1);
          cnt    <= '0;
          mode_q <= mode_in;
        end
        ST_SETTLE: begin
          if (cnt == CNT_LAST) state <= ST_GAP;
          else                 cnt   <= cnt + 1'b1;
        end
        ST_GAP: begin
          if (code == OFS_MAX) begin
            state <= ST_CALC;
          end else begin
            code  <= code + 1'b1;
            cnt   <= '0;
            state <= ST_SETTLE;
          end
        end
        ST_CALC: begin
          state <= ST_IDLE;
          code  <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe     = (state == ST_SETTLE);
    sample_now = (state == ST_SETTLE) && (cnt == CNT_LAST);
    clear_trk  = (state == ST_IDLE) && start;
    calc_now   = (state == ST_CALC);
    sweep_on   = (state == ST_SETTLE) || (state == ST_GAP);
  end
endmodule

// File: rtl/samp_cal_track.sv
module samp_cal_track
  import samp_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             fb_bit,
  input  logic [OFS_W-1:0] code,
  output logic [OFS_W-1:0] first_zero,
  output logic [OFS_W-1:0] last_one
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_zero <= '0;
      last_one   <= '0;
    end else if (clear) begin
      first_zero <= '0;
      last_one   <= '0;
    end else if (sample) begin
      if (fb_bit)                  last_one   <= code;
      else if (first_zero == '0)   first_zero <= code;
    end
  end
endmodule

// File: rtl/sampler_offset_cal.sv
module sampler_offset_cal
  import samp_cal_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int BASE_LANES = 8,
  parameter int MAX_LANES  = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     strobe_lane_en,
  input  logic [MAX_LANES-1:0]     fb,
  output logic [MAX_LANES*4-1:0]   ofs_word,
  output logic                     train_strobe,
  output logic [MAX_LANES*4-1:0]   result,
  output logic                     done
);
  localparam int WORD_W = MAX_LANES * OFS_W;

  logic [OFS_W-1:0]  code;
  logic              sample_now, clear_trk, calc_now, sweep_on, mode_q;
  logic [WORD_W-1:0] result_d;

  samp_cal_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_in   (strobe_lane_en),
    .code      (code),
    .strobe    (train_strobe),
    .sample_now(sample_now),
    .clear_trk (clear_trk),
    .calc_now  (calc_now),
    .sweep_on  (sweep_on),
    .mode_q    (mode_q)
  );

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    logic [OFS_W-1:0] fz, lo;
    logic             active;
    assign active = (i < BASE_LANES) || mode_q;

    samp_cal_track u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear_trk),
      .sample    (sample_now && active),
      .fb_bit    (fb[i]),
      .code      (code),
      .first_zero(fz),
      .last_one  (lo)
    );

    assign ofs_word[i*OFS_W +: OFS_W] = (sweep_on && active) ? code : '0;
    assign result_d[i*OFS_W +: OFS_W] = active ? centre_code(fz, lo) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= calc_now;
      if (calc_now) result <= result_d;
    end
  end
endmodule

// File: rtl/sampler_offset_cal_chk.sv
module sampler_offset_cal_chk
  import samp_cal_pkg::*;
#(
  parameter int MAX_LANES = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   done,
  input logic                   train_strobe,
  input logic                   sample_now,
  input logic                   sweep_on,
  input logic [OFS_W-1:0]       code,
  input logic [MAX_LANES*4-1:0] ofs_word,
  input logic [MAX_LANES*4-1:0] result
);
  // R10: completion pulse lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: result only moves when done is raised
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R3: feedback is taken on a strobe-high cycle and the strobe then drops
  assert_sample_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> train_strobe);
  assert_strobe_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |=> !train_strobe);

  // R2: trim word stays fixed while a pulse is high; code never 0 in a sweep
  assert_word_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (train_strobe && $past(train_strobe)) |-> $stable(ofs_word));
  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_on |-> (code != '0));

  // R11: a start during a sweep does not restart the code
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_on && start && code > OFS_W'(1)) |=> (code != OFS_W'(1)));
endmodule

bind sampler_offset_cal sampler_offset_cal_chk #(.MAX_LANES(MAX_LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .train_strobe(train_strobe),
  .sample_now  (sample_now),
  .sweep_on    (sweep_on),
  .code        (code),
  .ofs_word    (ofs_word),
  .result      (result)
);

// File: tb/sampler_offset_cal_tb.sv
module sampler_offset_cal_tb;
  localparam int SETTLE = 100;
  localparam int NL     = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            mode = 1'b0;
  logic [NL-1:0]   fb;
  logic [NL*4-1:0] ofs_word, result;
  logic            train_strobe, done;

  logic [15:0] pat [NL];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sampler_offset_cal #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe_lane_en(mode), .fb(fb),
    .ofs_word(ofs_word), .train_strobe(train_strobe), .result(result), .done(done)
  );

  // Feedback model: lane i reads pat[i][code applied to that lane]
  always_comb
    for (int i = 0; i < NL; i++) fb[i] = pat[i][ofs_word[i*4 +: 4]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_lane(input logic [15:0] m);
    int fz = 0, lo = 0, s;
    for (int c = 1; c <= 15; c++) begin
      if (m[c]) lo = c;
      else if (fz == 0) fz = c;
    end
    if (lo == 0) return 0;
    if (fz == 0) return 15;
    s = (fz + lo) / 2;
    return (s > 15) ? 15 : s;
  endfunction

  function automatic logic [15:0] thr(input int t);
    return ((16'h1 << t) - 16'h1) & 16'hFFFE;
  endfunction

  // One full run; optional mid-run start and mode toggle
  task automatic run_cal(input bit m, input bit poke, input string req);
    int rises = 0, hi = 0, lo = 0;
    bit prev = 1'b0, seen = 1'b0;
    logic [NL*4-1:0] res;
    @(negedge clk); mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 3000 && !seen; cyc++) begin
      if (poke && cyc == 500) begin start = 1'b1; mode = ~m; end
      if (poke && cyc == 501) start = 1'b0;
      if (train_strobe && !prev) begin
        rises++;
        if (rises > 1) chk(lo == 1, "R3 gap", lo, 1);
        hi = 1;
        for (int i = 0; i < NL; i++) begin
          if (i < 8 || m) chk(ofs_word[i*4 +: 4] == rises[3:0], "R2 field", ofs_word[i*4 +: 4], rises);
          else            chk(ofs_word[i*4 +: 4] == 0, "R9 lane8 idle", ofs_word[i*4 +: 4], 0);
        end
      end else if (train_strobe) hi++;
      else if (prev) begin
        chk(hi == SETTLE, "R3 width", hi, SETTLE);
        lo = 1;
      end else lo++;
      if (done) seen = 1'b1;
      prev = train_strobe;
      if (!seen) @(negedge clk);
    end
    chk(seen, "R10 done", seen, 1);
    chk(rises == 15, "R3 count", rises, 15);
    for (int i = 0; i < NL; i++) begin
      int e = (i < 8 || m) ? expect_lane(pat[i]) : 0;
      chk(result[i*4 +: 4] == e, req, result[i*4 +: 4], e);
    end
    res = result;
    mode = 1'b0;
    @(negedge clk);
    chk(!done, "R10 one-cycle", done, 0);
    repeat (20) @(negedge clk);
    chk(result == res, "R10 hold", 0, 0);
  endtask

  task automatic t_reset();
    chk(!done && !train_strobe, "R1 ctrl", {done, train_strobe}, 0);
    chk(ofs_word == 0, "R1 ofs", ofs_word[31:0], 0);
    chk(result == 0, "R1 result", result[31:0], 0);
  endtask

  task automatic t_thresholds();  // R4 R5 R6 monotonic windows
    for (int i = 0; i < NL; i++) pat[i] = thr(2 + i);
    run_cal(1'b0, 1'b0, "R6 centre");
  endtask

  task automatic t_saturation();  // R7 R8
    pat[0] = 16'hFFFF; pat[1] = 16'h0000; pat[2] = thr(15); pat[3] = 16'h0002;
    pat[4] = 16'h8000; pat[5] = 16'h7FFE; pat[6] = thr(8); pat[7] = 16'hFFFE; pat[8] = 0;
    run_cal(1'b0, 1'b0, "R7 R8 saturation");
  endtask

  task automatic t_noisy();       // R4 R5 non-monotonic
    pat[0] = 16'b0000_0010_0010_0110; pat[1] = 16'b1000_0000_0000_0010;
    pat[2] = 16'b0101_0101_0101_0100; pat[3] = 16'b0010_0000_0000_1110;
    pat[4] = 16'b0000_0000_1100_0000; pat[5] = thr(4);
    pat[6] = 16'b1010_1010_1010_1010; pat[7] = 16'b0000_0001_1111_1110; pat[8] = 0;
    run_cal(1'b0, 1'b0, "R4 R5 noisy");
  endtask

  task automatic t_strobe_lane(); // R9
    for (int i = 0; i < NL; i++) pat[i] = thr(14 - i);
    pat[8] = 16'b0000_0100_1101_1110;
    run_cal(1'b1, 1'b0, "R9 ninth lane");
  endtask

  task automatic t_ignore_start(); // R11
    for (int i = 0; i < NL; i++) pat[i] = thr(5 + i);
    run_cal(1'b0, 1'b1, "R11 mid-run start");
  endtask

  initial begin
    for (int i = 0; i < NL; i++) pat[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_thresholds();
    t_saturation();
    t_noisy();
    t_strobe_lane();
    t_ignore_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule